// File: doc/BRIEF.md
# Machine Timer Compare Unit

This block is a core-local machine timer. It holds a free-running time count split into a low and a high half, and it advances the count by one on every retired-instruction tick. At each tick the advanced count is compared against a compare value that software writes. When the count has reached the compare value, a machine timer pending bit is set. That bit stays set until the trap logic clears it.

The block also holds a one-bit software interrupt flag. Software reaches the flag, the compare halves and the time count through a small register port. The port takes byte-lane write enables. Reads are combinational from the current state.

A compare value of all zeros means the timer has never been armed. In that state the block never fires. The half width is a parameter (default 32 bits), so the full count is twice that width.

Register slots, each one half-word wide, are at byte address slot × (HALF_W/8). Address bits below the slot size are ignored. The slots are:
- slot 0: software flag, in bit 0.
- slot 1: compare low half.
- slot 2: compare high half.
- slot 3: time low half, read-only.
- slot 4: time high half, read-only.

Top module: `mtimer_cmp`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: both time halves, both compare halves, the software flag and the pending output.
- R2: On a cycle with tick_i high, the low time half increases by one. On a cycle without a tick, neither time half changes.
- R3: The high time half increases by one only on the tick where the low half wraps from all ones to zero. On every other tick it holds.
- R4: On a tick, the pending bit is set when the advanced count has reached the compare value. That is the case when the high half is above the compare high half, or when the high halves are equal and the low half is at or above the compare low half. The pending bit can only rise after a tick cycle.
- R5: While both compare halves are zero, the pending bit never becomes set.
- R6: Once set, the pending bit stays set until clr_i is high. A cycle with clr_i high leaves the bit clear after that edge, even if the same cycle also fires. A later tick that meets the rule sets it again.
- R7: A write updates only the byte lanes of the compare half whose bus_be_i bit is high. Writes to slots 3 and 4 change nothing.
- R8: A compare write made in the same cycle as a tick does not affect that tick's comparison. It takes effect from the next tick.
- R9: Slot 0 reads back 0 or 1, with all upper bits zero. A write with lane 0 enabled loads bit 0 of the write data into the flag. sw_irq_o shows the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Retired-instruction tick strobe |
| clr_i | input | 1 | Pending clear from the trap logic |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address of the register slot |
| bus_be_i | input | HALF_W/8 | Byte-lane write enables |
| bus_wdata_i | input | HALF_W | Write data |
| bus_rdata_o | output | HALF_W | Read data for the addressed slot |
| sw_irq_o | output | 1 | Software interrupt flag |
| timer_irq_o | output | 1 | Machine timer pending bit |

## Verification
The hardest situation to reach from the ports is the carry into the high half. With 32-bit halves it needs four billion ticks, and the count has no write path. The bench therefore builds the block with 16-bit halves. It steps the tick more than 65,000 times with the compare value disarmed, so the carry happens without interference from the pending bit. After that, the equal-high and greater-high firing rules are exercised against a high half that is no longer zero. A tick that coincides with a compare write, and a clear that coincides with a firing tick, are each driven in a single cycle.

// File: rtl/mtc_pkg.sv
// Shared definitions for the machine timer compare unit.
// Assumes register slots are one half-word wide and indexed from zero.
package mtc_pkg;

    // Register slot indices as seen on the register port.
    typedef enum logic [2:0] {
        SLOT_SWFLAG  = 3'd0,
        SLOT_CMP_LO  = 3'd1,
        SLOT_CMP_HI  = 3'd2,
        SLOT_TIME_LO = 3'd3,
        SLOT_TIME_HI = 3'd4
    } mtc_slot_e;

    localparam int unsigned SLOT_COUNT = 5;

endpackage

// File: rtl/mtc_time_count.sv
// Two-half free-running time count.
// The low half steps on each tick. The high half takes the carry out of the low half.
// Also provides the value the count will take on a tick, for the compare logic.
// Assumes tick_i is a single-cycle strobe in the clk domain.
module mtc_time_count #(
    parameter int unsigned HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    output logic [HALF_W-1:0] lo_o,
    output logic [HALF_W-1:0] hi_o,
    output logic [HALF_W-1:0] lo_adv_o,
    output logic [HALF_W-1:0] hi_adv_o
);

    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] hi_q;
    logic              wrap;

    // Advanced value: the carry is taken only when the low half is all ones.
    always_comb begin
        wrap     = &lo_q;
        lo_adv_o = lo_q + HALF_W'(1);
        hi_adv_o = wrap ? (hi_q + HALF_W'(1)) : hi_q;
    end

    // Count register: load the advanced value on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (tick_i) begin
            lo_q <= lo_adv_o;
            hi_q <= hi_adv_o;
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;

endmodule

// File: rtl/mtc_cmp_store.sv
// Compare value storage: two halves, each written through byte-lane enables.
// Assumes the write strobes for the two halves are never high together.
module mtc_cmp_store #(
    parameter int unsigned HALF_W = 32,
    localparam int unsigned LANES = HALF_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [HALF_W-1:0] wdata_i,
    output logic [HALF_W-1:0] cmp_lo_o,
    output logic [HALF_W-1:0] cmp_hi_o,
    output logic              armed_o
);

    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] hi_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One byte lane of each half: load only when its enable is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[g*8 +: 8] <= '0;
                hi_q[g*8 +: 8] <= '0;
            end else begin
                if (wr_lo_i && be_i[g]) lo_q[g*8 +: 8] <= wdata_i[g*8 +: 8];
                if (wr_hi_i && be_i[g]) hi_q[g*8 +: 8] <= wdata_i[g*8 +: 8];
            end
        end
    end

    // Armed whenever any compare bit is non-zero.
    always_comb begin
        armed_o = (|lo_q) || (|hi_q);
    end

    assign cmp_lo_o = lo_q;
    assign cmp_hi_o = hi_q;

endmodule

// File: rtl/mtc_match.sv
// Half-by-half comparison of a count against the compare value.
// Reports reached when the high half is above, or equal with the low half at or above.
// Purely combinational; assumes unsigned operands.
module mtc_match #(
    parameter int unsigned HALF_W = 32
) (
    input  logic [HALF_W-1:0] cnt_lo_i,
    input  logic [HALF_W-1:0] cnt_hi_i,
    input  logic [HALF_W-1:0] cmp_lo_i,
    input  logic [HALF_W-1:0] cmp_hi_i,
    output logic              reached_o
);

    logic hi_above;
    logic hi_equal;
    logic lo_at_or_above;

    // Split comparison keeps each comparator one half wide.
    always_comb begin
        hi_above       = cnt_hi_i > cmp_hi_i;
        hi_equal       = cnt_hi_i == cmp_hi_i;
        lo_at_or_above = cnt_lo_i >= cmp_lo_i;
        reached_o      = hi_above || (hi_equal && lo_at_or_above);
    end

endmodule

// File: rtl/mtc_bus_decode.sv
// Register port decode: turns a byte address into a slot index and per-slot write strobes.
// Address bits below the slot size are ignored.
module mtc_bus_decode #(
    parameter int unsigned HALF_W = 32,
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned LANES = HALF_W / 8,
    localparam int unsigned LSB   = (LANES > 1) ? $clog2(LANES) : 0,
    localparam int unsigned IDX_W = ADDR_W - LSB
) (
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              wr_sw_o,
    output logic              wr_cmp_lo_o,
    output logic              wr_cmp_hi_o
);

    import mtc_pkg::*;

    // Slot index and write strobes for the writable slots.
    always_comb begin
        idx_o       = addr_i[ADDR_W-1:LSB];
        wr_sw_o     = we_i && (idx_o == IDX_W'(SLOT_SWFLAG));
        wr_cmp_lo_o = we_i && (idx_o == IDX_W'(SLOT_CMP_LO));
        wr_cmp_hi_o = we_i && (idx_o == IDX_W'(SLOT_CMP_HI));
    end

endmodule

// File: rtl/mtimer_cmp.sv
// Machine timer compare unit, top level.
// Counts ticks into a two-half time count. On each tick it compares the advanced count with the
// compare value and sets a sticky pending bit. It also holds a software interrupt flag.
// Assumes a single clock and a synchronous active-low reset. clr_i has priority over a firing tick.
module mtimer_cmp #(
    parameter int unsigned HALF_W = 32,
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned LANES = HALF_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              clr_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [LANES-1:0]  bus_be_i,
    input  logic [HALF_W-1:0] bus_wdata_i,
    output logic [HALF_W-1:0] bus_rdata_o,
    output logic              sw_irq_o,
    output logic              timer_irq_o
);

    import mtc_pkg::*;

    localparam int unsigned LSB   = (LANES > 1) ? $clog2(LANES) : 0;
    localparam int unsigned IDX_W = ADDR_W - LSB;

    logic [IDX_W-1:0]  slot_idx;
    logic              wr_sw;
    logic              wr_cmp_lo;
    logic              wr_cmp_hi;
    logic [HALF_W-1:0] time_lo;
    logic [HALF_W-1:0] time_hi;
    logic [HALF_W-1:0] adv_lo;
    logic [HALF_W-1:0] adv_hi;
    logic [HALF_W-1:0] cmp_lo;
    logic [HALF_W-1:0] cmp_hi;
    logic              armed;
    logic              reached;
    logic              fire;
    logic              pend_q;
    logic              sw_q;

    mtc_bus_decode #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_dec (
        .we_i        (bus_we_i),
        .addr_i      (bus_addr_i),
        .idx_o       (slot_idx),
        .wr_sw_o     (wr_sw),
        .wr_cmp_lo_o (wr_cmp_lo),
        .wr_cmp_hi_o (wr_cmp_hi)
    );

    mtc_time_count #(.HALF_W(HALF_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .lo_o     (time_lo),
        .hi_o     (time_hi),
        .lo_adv_o (adv_lo),
        .hi_adv_o (adv_hi)
    );

    mtc_cmp_store #(.HALF_W(HALF_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo_i  (wr_cmp_lo),
        .wr_hi_i  (wr_cmp_hi),
        .be_i     (bus_be_i),
        .wdata_i  (bus_wdata_i),
        .cmp_lo_o (cmp_lo),
        .cmp_hi_o (cmp_hi),
        .armed_o  (armed)
    );

    mtc_match #(.HALF_W(HALF_W)) u_match (
        .cnt_lo_i  (adv_lo),
        .cnt_hi_i  (adv_hi),
        .cmp_lo_i  (cmp_lo),
        .cmp_hi_i  (cmp_hi),
        .reached_o (reached)
    );

    // Fire only on a tick, only when armed, using the compare value held before any write this cycle.
    always_comb begin
        fire = tick_i && armed && reached;
    end

    // Sticky pending bit: clear wins, otherwise set on fire.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (clr_i) pend_q <= 1'b0;
        else if (fire)  pend_q <= 1'b1;
    end

    // Software flag: bit 0 of lane 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                     sw_q <= 1'b0;
        else if (wr_sw && bus_be_i[0])  sw_q <= bus_wdata_i[0];
    end

    // Read mux over the register slots.
    always_comb begin
        bus_rdata_o = '0;
        if (slot_idx == IDX_W'(SLOT_SWFLAG))       bus_rdata_o = {{(HALF_W-1){1'b0}}, sw_q};
        else if (slot_idx == IDX_W'(SLOT_CMP_LO))  bus_rdata_o = cmp_lo;
        else if (slot_idx == IDX_W'(SLOT_CMP_HI))  bus_rdata_o = cmp_hi;
        else if (slot_idx == IDX_W'(SLOT_TIME_LO)) bus_rdata_o = time_lo;
        else if (slot_idx == IDX_W'(SLOT_TIME_HI)) bus_rdata_o = time_hi;
    end

    assign sw_irq_o    = sw_q;
    assign timer_irq_o = pend_q;

endmodule

// File: rtl/mtimer_cmp_chk.sv
// Property checker for the machine timer compare unit, bound to every instance of the top.
// Observes ports and internal state. Drives nothing.
module mtimer_cmp_chk #(
    parameter int unsigned HALF_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              clr_i,
    input logic              bus_we_i,
    input logic [HALF_W-1:0] time_lo,
    input logic [HALF_W-1:0] time_hi,
    input logic [HALF_W-1:0] cmp_lo,
    input logic [HALF_W-1:0] cmp_hi,
    input logic              sw_irq_o,
    input logic              timer_irq_o
);

    assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> time_lo == HALF_W'($past(time_lo) + HALF_W'(1)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(time_lo) && $stable(time_hi));

    assert_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (&time_lo)) |=> time_hi == HALF_W'($past(time_hi) + HALF_W'(1)));

    assert_no_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !(&time_lo)) |=> $stable(time_hi));

    assert_rise_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !timer_irq_o) |=> !timer_irq_o);

    assert_disarmed_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_lo == '0 && cmp_hi == '0 && !timer_irq_o) |=> !timer_irq_o);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_irq_o && !clr_i) |=> timer_irq_o);

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !timer_irq_o);

    assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_i |=> $stable(cmp_lo) && $stable(cmp_hi));

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_i |=> $stable(sw_irq_o));

endmodule

bind mtimer_cmp mtimer_cmp_chk #(.HALF_W(HALF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .clr_i       (clr_i),
    .bus_we_i    (bus_we_i),
    .time_lo     (time_lo),
    .time_hi     (time_hi),
    .cmp_lo      (cmp_lo),
    .cmp_hi      (cmp_hi),
    .sw_irq_o    (sw_irq_o),
    .timer_irq_o (timer_irq_o)
);

// File: tb/test_mtimer_cmp.sv
// Scoreboard bench. Driver tasks update a reference model and push expected read results.
// A monitor pops each result two time units after the read cycle's clock edge and compares it.
module test_mtimer_cmp;

    localparam int unsigned HW    = 16;
    localparam int unsigned AW    = 5;
    localparam int unsigned LN    = HW / 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick;
    logic          clr;
    logic          we;
    logic [AW-1:0] addr;
    logic [LN-1:0] be;
    logic [HW-1:0] wdata;
    logic [HW-1:0] rdata;
    logic          sw_irq;
    logic          t_irq;

    int checks = 0;
    int fails  = 0;

    // Reference model state.
    logic [HW-1:0] m_lo, m_hi, m_clo, m_chi;
    logic          m_sw, m_pend;

    // Scoreboard queues, one entry per read.
    logic [HW-1:0] q_data[$];
    logic          q_pend[$];
    logic          q_sw[$];
    string         q_tag[$];

    always #5 clk = ~clk;

    mtimer_cmp #(.HALF_W(HW), .ADDR_W(AW)) i_mtimer_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .clr_i       (clr),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_be_i    (be),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .sw_irq_o    (sw_irq),
        .timer_irq_o (t_irq)
    );

    // One cycle of stimulus. The model evaluates the tick with the old compare value, then applies the write.
    task automatic act(input logic tk, input logic cl, input logic w, input int idx,
                       input logic [LN-1:0] b, input logic [HW-1:0] d);
        logic [2*HW-1:0] nxt;
        logic            hit;
        @(negedge clk);
        tick = tk; clr = cl; we = w; addr = AW'(idx * LN); be = b; wdata = d;
        hit = 1'b0;
        if (tk) begin
            nxt = {m_hi, m_lo} + 1;
            {m_hi, m_lo} = nxt;
            hit = ({m_chi, m_clo} != 0) && (nxt >= {m_chi, m_clo});
        end
        if (cl)       m_pend = 1'b0;
        else if (hit) m_pend = 1'b1;
        if (w) begin
            for (int l = 0; l < int'(LN); l++) begin
                if (b[l] && idx == 1) m_clo[l*8 +: 8] = d[l*8 +: 8];
                if (b[l] && idx == 2) m_chi[l*8 +: 8] = d[l*8 +: 8];
            end
            if (idx == 0 && b[0]) m_sw = d[0];
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) act(1'b1, 1'b0, 1'b0, 0, '0, '0);
    endtask

    task automatic wr(input int idx, input logic [LN-1:0] b, input logic [HW-1:0] d);
        act(1'b0, 1'b0, 1'b1, idx, b, d);
    endtask

    // Idle read cycle: push the model's view for the monitor.
    task automatic rd(input int idx, input string tag);
        logic [HW-1:0] e;
        @(negedge clk);
        tick = 1'b0; clr = 1'b0; we = 1'b0; be = '0; wdata = '0; addr = AW'(idx * LN);
        case (idx)
            0: e = {{(HW-1){1'b0}}, m_sw};
            1: e = m_clo;
            2: e = m_chi;
            3: e = m_lo;
            default: e = m_hi;
        endcase
        q_data.push_back(e); q_pend.push_back(m_pend); q_sw.push_back(m_sw); q_tag.push_back(tag);
    endtask

    // Monitor: compare the read data and both interrupt outputs.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_data.size() != 0) begin
                logic [HW-1:0] ed;
                logic          ep, es;
                string         tg;
                ed = q_data.pop_front(); ep = q_pend.pop_front();
                es = q_sw.pop_front();   tg = q_tag.pop_front();
                checks++;
                if (rdata !== ed || t_irq !== ep || sw_irq !== es) begin
                    fails++;
                    $display("FAIL %s: rdata=%h pend=%b sw=%b expected rdata=%h pend=%b sw=%b",
                             tg, rdata, t_irq, sw_irq, ed, ep, es);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: cycles=200000 expected completion earlier");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick = 0; clr = 0; we = 0; addr = '0; be = '0; wdata = '0;
        m_lo = '0; m_hi = '0; m_clo = '0; m_chi = '0; m_sw = 1'b0; m_pend = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every slot
        for (int s = 0; s < 5; s++) rd(s, "R1");
        // R9: flag reads 0/1 and only lane 0 loads it
        wr(0, 2'b11, 16'hFFFF); rd(0, "R9");
        wr(0, 2'b10, 16'h0000); rd(0, "R9");
        wr(0, 2'b01, 16'h0000); rd(0, "R9");
        // R2: counting on ticks, holding when idle
        ticks(5); rd(3, "R2"); rd(3, "R2"); rd(4, "R2");
        // R7: byte lanes and read-only time slots
        wr(1, 2'b01, 16'h1234); rd(1, "R7");
        wr(1, 2'b10, 16'hAB00); rd(1, "R7");
        wr(1, 2'b00, 16'hFFFF); rd(1, "R7");
        wr(3, 2'b11, 16'h7777); rd(3, "R7");
        wr(4, 2'b11, 16'h7777); rd(4, "R7");
        // R4: fire exactly when the low half reaches the compare low half
        wr(1, 2'b11, 16'd20);
        ticks(14); rd(3, "R4");
        ticks(1);  rd(3, "R4");
        // R6: sticky, clear beats a firing tick, then sets again
        ticks(3); rd(3, "R6");
        act(1'b1, 1'b1, 1'b0, 0, '0, '0); rd(3, "R6");
        ticks(1); rd(3, "R6");
        // R4: high half below the compare high half does not fire
        wr(2, 2'b11, 16'd1);
        act(1'b0, 1'b1, 1'b0, 0, '0, '0);
        ticks(4); rd(3, "R4");
        // R8: a compare write in the tick's own cycle is not seen by that tick
        act(1'b1, 1'b0, 1'b1, 2, 2'b11, 16'd0); rd(2, "R8");
        ticks(1); rd(3, "R8");
        // R5: disarmed compare never fires
        wr(1, 2'b11, 16'd0);
        act(1'b0, 1'b1, 1'b0, 0, '0, '0);
        ticks(10); rd(3, "R5");
        // R3: carry into the high half
        ticks(int'(16'hFFFF - m_lo));
        rd(3, "R3"); rd(4, "R3");
        ticks(1);
        rd(3, "R3"); rd(4, "R3");
        // R4: equal high halves, low half at or above
        wr(2, 2'b11, 16'd1); wr(1, 2'b11, 16'd5);
        ticks(4); rd(3, "R4");
        ticks(1); rd(3, "R4");
        act(1'b0, 1'b1, 1'b0, 0, '0, '0); rd(3, "R6");
        ticks(1); rd(3, "R4");
        // R4: high half above the compare high half fires whatever the low halves are
        wr(2, 2'b11, 16'd0); wr(1, 2'b11, 16'hFFFF);
        act(1'b0, 1'b1, 1'b0, 0, '0, '0); rd(3, "R6");
        ticks(1); rd(3, "R4");
        // Drain the scoreboard.
        act(1'b0, 1'b0, 1'b0, 0, '0, '0);
        act(1'b0, 1'b0, 1'b0, 0, '0, '0);
        if (q_data.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: %0d left expected 0", q_data.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule